// File: doc/BRIEF.md
# Byte-compare terminated string loader

This block copies a run of bytes from a byte-wide memory read port into consecutive 32-bit registers of an external register file. The bytes fill each register from its most significant lane downward. After the least significant lane the block moves to the next register, and register numbers wrap around. Each byte is merged into the register through a read-modify-write, so lanes that were not loaded keep their old contents.

The run ends early when a fetched byte equals a programmed compare value. That byte is still written. When the run completes, the block returns the position of the terminating byte, or the full count if no byte matched. Two registers can be named as protected: the base register and the index register. Bytes that land in a protected register are fetched but not written. In 32-bit addressing mode the byte address wraps within 32 bits.

The caller pulses start with the operands. It then waits for a one-cycle done pulse, which carries the result.

Top module: `strload_cmp`

## Requirements
- R1: Each fetched byte is written into one 8-bit lane of the current register. The other 24 bits keep the value they held before the write.
- R2: The first byte goes to bits 31:24 of the first register, the next to bits 23:16, then 15:8, then 7:0. The following byte starts again at bits 31:24 of the next register.
- R3: The register number after 31 is 0.
- R4: A register whose number equals the index register operand receives no write. A register whose number equals a nonzero base register operand also receives no write. In both cases its byte is still fetched and the lane sequence advances as usual.
- R5: A fetched byte equal to the compare value is written as usual, and no further read is issued after it. A run issues exactly one read per byte it consumes, and no reads or writes occur outside a run.
- R6: result_o equals the zero-based position of the terminating byte. If no byte matched, it equals the programmed count.
- R7: Each read address is the previous one plus 1. With mode32_i high, the sum is truncated to 32 bits, so 0xFFFF_FFFF is followed by 0. With mode32_i low, the address carries into the upper bits.
- R8: A count of 0 issues no read and no write, and raises done_o in the cycle after start_i, with result_o equal to 0.
- R9: done_o is high for exactly one cycle per run, and result_o is valid in that cycle. start_i is ignored while a run is in progress.
- R10: After reset, done_o, mem_req_o and rf_we_o are low and result_o is 0.
- R11: mem_req_o is a one-cycle pulse. A new request is issued only after the data for the previous request has arrived with mem_rvalid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; operands are sampled in the same cycle |
| addr_i | input | AW | Address of the first byte |
| count_i | input | CNT_W | Maximum number of bytes to load |
| cmp_i | input | 8 | Terminating byte value |
| first_reg_i | input | 5 | First destination register |
| base_reg_i | input | 5 | Base register operand; protected when nonzero |
| index_reg_i | input | 5 | Index register operand; always protected |
| mode32_i | input | 1 | Wrap the byte address within 32 bits |
| mem_req_o | output | 1 | Byte read request pulse |
| mem_addr_o | output | AW | Byte read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data |
| rf_raddr_o | output | 5 | Register read address (combinational read) |
| rf_rdata_i | input | 32 | Register read data |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write address |
| rf_wdata_o | output | 32 | Merged register write data |
| done_o | output | 1 | Run complete, one cycle |
| result_o | output | CNT_W | Terminating position or count |

## Verification
The assertions assume the following about the environment:
- mem_rvalid_i returns exactly one response per request, and only after that request.
- The register file returns the addressed word combinationally and commits writes at the clock edge.
- Operands on the start inputs are meaningful only in the cycle in which start_i is accepted.

The bench memory follows these rules. It holds one pending response and gives it back after a latency of one to three cycles, varied from run to run. It flags any request made while a response is still pending. Every byte comes from an odd multiplier applied to the low address byte. Bytes within a run are therefore distinct, which places a match exactly where the compare value is chosen.

// File: rtl/strload_pkg.sv
`timescale 1ns/1ps
package strload_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } sl_state_e;
endpackage

// File: rtl/strload_lane_ins.sv
`timescale 1ns/1ps
module strload_lane_ins #(
  parameter int REG_W  = 32,
  parameter int LANE_W = 2
) (
  input  logic [REG_W-1:0]  old_i,
  input  logic [7:0]        byte_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [REG_W-1:0]  new_o
);
  localparam int LANES = REG_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign new_o[8*g +: 8] = (lane_i == LANE_W'(g)) ? byte_i : old_i[8*g +: 8];
  end
endmodule

// File: rtl/strload_addr_inc.sv
`timescale 1ns/1ps
module strload_addr_inc #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] addr_i,
  input  logic          m32_i,
  output logic [AW-1:0] nxt_o
);
  if (AW > 32) begin : g_trunc
    logic [31:0] low_inc;
    assign low_inc = addr_i[31:0] + 32'd1;
    assign nxt_o   = m32_i ? {{(AW-32){1'b0}}, low_inc} : addr_i + AW'(1);
  end else begin : g_flat
    logic unused_m32;
    assign unused_m32 = m32_i;
    assign nxt_o      = addr_i + AW'(1);
  end
endmodule

// File: rtl/strload_guard.sv
`timescale 1ns/1ps
module strload_guard #(
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] cur_i,
  input  logic [RIDX_W-1:0] base_i,
  input  logic [RIDX_W-1:0] index_i,
  output logic              allow_o
);
  logic hit_index, hit_base;
  assign hit_index = (cur_i == index_i);
  assign hit_base  = (base_i != '0) && (cur_i == base_i);
  assign allow_o   = !(hit_index || hit_base);
endmodule

// File: rtl/strload_cmp.sv
`timescale 1ns/1ps
module strload_cmp
  import strload_pkg::*;
#(
  parameter int AW    = 64,
  parameter int CNT_W = 7,
  parameter int NREG  = 32,
  parameter int REG_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [CNT_W-1:0]        count_i,
  input  logic [7:0]              cmp_i,
  input  logic [$clog2(NREG)-1:0] first_reg_i,
  input  logic [$clog2(NREG)-1:0] base_reg_i,
  input  logic [$clog2(NREG)-1:0] index_reg_i,
  input  logic                    mode32_i,
  output logic                    mem_req_o,
  output logic [AW-1:0]           mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [7:0]              mem_rdata_i,
  output logic [$clog2(NREG)-1:0] rf_raddr_o,
  input  logic [REG_W-1:0]        rf_rdata_i,
  output logic                    rf_we_o,
  output logic [$clog2(NREG)-1:0] rf_waddr_o,
  output logic [REG_W-1:0]        rf_wdata_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        result_o
);
  localparam int RIDX_W = $clog2(NREG);
  localparam int LANES  = REG_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(LANES - 1);
  localparam logic [RIDX_W-1:0] REG_LAST = RIDX_W'(NREG - 1);

  sl_state_e         state_q;
  logic [AW-1:0]     addr_q;
  logic [CNT_W-1:0]  cnt_q, idx_q;
  logic [RIDX_W-1:0] reg_q, base_q, index_q;
  logic [LANE_W-1:0] lane_q;
  logic [7:0]        cmp_q;
  logic              m32_q;

  logic [AW-1:0]     addr_nx;
  logic [REG_W-1:0]  merged;
  logic              wr_ok;
  logic              hit;
  logic [CNT_W-1:0]  idx_inc;
  logic              last_byte;
  logic [RIDX_W-1:0] reg_nx;

  strload_addr_inc #(.AW(AW)) u_inc (
    .addr_i (addr_q),
    .m32_i  (m32_q),
    .nxt_o  (addr_nx)
  );

  strload_lane_ins #(.REG_W(REG_W), .LANE_W(LANE_W)) u_ins (
    .old_i  (rf_rdata_i),
    .byte_i (mem_rdata_i),
    .lane_i (lane_q),
    .new_o  (merged)
  );

  strload_guard #(.RIDX_W(RIDX_W)) u_grd (
    .cur_i   (reg_q),
    .base_i  (base_q),
    .index_i (index_q),
    .allow_o (wr_ok)
  );

  assign hit       = (mem_rdata_i == cmp_q);
  assign idx_inc   = idx_q + CNT_W'(1);
  assign last_byte = (idx_inc == cnt_q);
  assign reg_nx    = (reg_q == REG_LAST) ? '0 : reg_q + RIDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      reg_q   <= '0;
      base_q  <= '0;
      index_q <= '0;
      lane_q  <= '0;
      cmp_q   <= '0;
      m32_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q  <= addr_i;
            cnt_q   <= count_i;
            idx_q   <= '0;
            reg_q   <= first_reg_i;
            base_q  <= base_reg_i;
            index_q <= index_reg_i;
            lane_q  <= LANE_TOP;
            cmp_q   <= cmp_i;
            m32_q   <= mode32_i;
            state_q <= (count_i == '0) ? ST_FIN : ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (hit) begin
              state_q <= ST_FIN;       // idx_q already holds the match position
            end else begin
              idx_q   <= idx_inc;
              addr_q  <= addr_nx;
              state_q <= last_byte ? ST_FIN : ST_ISSUE;
              if (lane_q == '0) begin
                lane_q <= LANE_TOP;
                reg_q  <= reg_nx;
              end else begin
                lane_q <= lane_q - LANE_W'(1);
              end
            end
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = (state_q == ST_ISSUE);
    mem_addr_o = addr_q;
    rf_raddr_o = reg_q;
    rf_waddr_o = reg_q;
    rf_wdata_o = merged;
    rf_we_o    = (state_q == ST_WAIT) && mem_rvalid_i && wr_ok;
    done_o     = (state_q == ST_FIN);
    result_o   = done_o ? idx_q : '0;
  end
endmodule

// File: rtl/strload_cmp_chk.sv
`timescale 1ns/1ps
module strload_cmp_chk #(
  parameter int AW    = 64,
  parameter int CNT_W = 7,
  parameter int NREG  = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [CNT_W-1:0]        count_i,
  input logic [$clog2(NREG)-1:0] base_reg_i,
  input logic [$clog2(NREG)-1:0] index_reg_i,
  input logic                    mode32_i,
  input logic                    mem_req_o,
  input logic [AW-1:0]           mem_addr_o,
  input logic                    mem_rvalid_i,
  input logic                    rf_we_o,
  input logic [$clog2(NREG)-1:0] rf_waddr_o,
  input logic                    done_o,
  input logic [CNT_W-1:0]        result_o
);
  localparam int RIDX_W = $clog2(NREG);
  localparam logic [AW-1:0] LOW32 = AW'(64'hFFFF_FFFF);

  logic              busy_c, have_last, m32_c;
  logic [CNT_W-1:0]  cnt_c;
  logic [RIDX_W-1:0] base_c, index_c;
  logic [AW-1:0]     last_c, step_c;

  assign step_c = m32_c ? ((last_c + AW'(1)) & LOW32) : (last_c + AW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_c    <= 1'b0;
      have_last <= 1'b0;
      m32_c     <= 1'b0;
      cnt_c     <= '0;
      base_c    <= '0;
      index_c   <= '0;
      last_c    <= '0;
    end else begin
      if (done_o) begin
        busy_c <= 1'b0;
      end else if (start_i && !busy_c) begin
        busy_c    <= 1'b1;
        have_last <= 1'b0;
        m32_c     <= mode32_i;
        cnt_c     <= count_i;
        base_c    <= base_reg_i;
        index_c   <= index_reg_i;
      end
      if (mem_req_o) begin
        last_c    <= mem_addr_o;
        have_last <= 1'b1;
      end
    end
  end

  AST_WE_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> mem_rvalid_i);  // R1
  AST_GUARD_RB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_waddr_o != index_c));  // R4
  AST_GUARD_RA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && base_c != '0) |-> (rf_waddr_o != base_c));  // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_c |-> (!mem_req_o && !rf_we_o));  // R5
  AST_RESULT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o <= cnt_c));  // R6
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_c && mem_req_o && have_last) |-> (mem_addr_o == step_c));  // R7
  AST_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_c && count_i == '0) |=> (done_o && result_o == '0));  // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R9
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);  // R11
endmodule

bind strload_cmp strload_cmp_chk #(.AW(AW), .CNT_W(CNT_W), .NREG(NREG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .count_i      (count_i),
  .base_reg_i   (base_reg_i),
  .index_reg_i  (index_reg_i),
  .mode32_i     (mode32_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .rf_we_o      (rf_we_o),
  .rf_waddr_o   (rf_waddr_o),
  .done_o       (done_o),
  .result_o     (result_o)
);

// File: tb/sim_strload_cmp.sv
`timescale 1ns/1ps
module sim_strload_cmp;
  localparam int AW = 64, CNT_W = 7, NREG = 32, REG_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             start = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [CNT_W-1:0] count = '0;
  logic [7:0]       cmp = '0;
  logic [4:0]       first_reg = '0, base_reg = '0, index_reg = '0;
  logic             mode32 = 1'b0;
  logic             mem_req, mem_rvalid;
  logic [AW-1:0]    mem_addr;
  logic [7:0]       mem_rdata;
  logic [4:0]       rf_raddr, rf_waddr;
  logic [REG_W-1:0] rf_rdata, rf_wdata;
  logic             rf_we, done;
  logic [CNT_W-1:0] result;

  int tests = 0, fails = 0;
  int lat = 1;
  logic [REG_W-1:0] rf [NREG];
  logic [REG_W-1:0] exp_rf [NREG];
  int acc_total = 0;
  logic [AW-1:0] last_acc = '0;
  bit overlap_err = 1'b0;
  int pend = 0;
  logic [AW-1:0] paddr = '0;

  strload_cmp #(.AW(AW), .CNT_W(CNT_W), .NREG(NREG), .REG_W(REG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .count_i(count),
    .cmp_i(cmp), .first_reg_i(first_reg), .base_reg_i(base_reg), .index_reg_i(index_reg),
    .mode32_i(mode32), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .rf_raddr_o(rf_raddr),
    .rf_rdata_i(rf_rdata), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .done_o(done), .result_o(result));

  function automatic logic [7:0] fbyte(input logic [AW-1:0] a);
    return 8'(a[7:0] * 8'd37 + 8'd11);
  endfunction

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 32'hA5C3_0000 ^ (32'h0101_0101 * i);
    end else if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
    end
  end

  // byte memory with per-run latency, one response per request
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (!rst_n) begin
      pend <= 0;
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (pend != 0) overlap_err <= 1'b1;
      pend      <= lat;
      paddr     <= mem_addr;
      acc_total <= acc_total + 1;
      last_acc  <= mem_addr;
    end else if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= fbyte(paddr);
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [AW-1:0] a0, input int cnt,
                        input logic [7:0] cv, input int first, input int ra, input int rb,
                        input bit m32, input bit poke);
    logic [AW-1:0] a = a0, exp_last = '0;
    int r = first, lane = 3, exp_res = cnt, exp_n = 0, acc0, ndone = 0, res = -1, after = -1;
    bit bad = 1'b0;
    int bad_i = 0;
    for (int i = 0; i < NREG; i++) exp_rf[i] = rf[i];
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] b = fbyte(a);
      exp_n++;
      exp_last = a;
      if (!(r == rb || (ra != 0 && r == ra))) exp_rf[r][8*lane +: 8] = b;
      if (b == cv) begin exp_res = i; break; end
      a = m32 ? {32'h0, a[31:0] + 32'd1} : a + 64'd1;
      if (lane == 0) begin lane = 3; r = (r + 1) % 32; end else lane--;
    end
    acc0 = acc_total;
    @(negedge clk);
    start = 1'b1; addr = a0; count = CNT_W'(cnt); cmp = cv;
    first_reg = 5'(first); base_reg = 5'(ra); index_reg = 5'(rb); mode32 = m32;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (k == 0 && poke) begin
        start = 1'b1; count = 7'd1; first_reg = 5'd0; cmp = fbyte(a0); addr = a0;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        ndone++;
        if (res < 0) begin res = int'(result); after = 0; end
      end
      if (after >= 0) begin
        after++;
        if (after > 4) break;
      end
    end
    chk({tag, " R9 done count"}, ndone == 1, ndone, 1);
    chk({tag, " R6 result"}, res == exp_res, res, exp_res);
    chk({tag, " R5 reads"}, acc_total - acc0 == exp_n, acc_total - acc0, exp_n);
    if (exp_n > 0) chk({tag, " R7 last address"}, last_acc == exp_last, last_acc, exp_last);
    for (int i = 0; i < NREG; i++)
      if (rf[i] !== exp_rf[i] && !bad) begin bad = 1'b1; bad_i = i; end
    chk({tag, " regfile"}, !bad, rf[bad_i], exp_rf[bad_i]);
  endtask

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog R9 act=running exp=finished");
    fails++;
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 done", done == 1'b0, done, 0);
    chk("R10 req", mem_req == 1'b0, mem_req, 0);
    chk("R10 we", rf_we == 1'b0, rf_we, 0);
    chk("R10 result", result == '0, result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3: counts across lanes and registers, several first registers, no match
    for (int c = 0; c <= 9; c++) begin
      for (int f = 0; f < 4; f++) begin
        int fr = (f == 0) ? 0 : (f == 1) ? 13 : (f == 2) ? 30 : 31;
        lat = 1 + (c + f) % 3;
        run_op(c == 0 ? "R8 zero" : "R2 R3 sweep", 64'h100 + 64'(c * 16 + f), c,
               fbyte(64'h100 + 64'(c * 16 + f + c)), fr, 0, (fr + 20) % 32, 1'b0, 1'b0);
      end
    end

    // R5 R6: match at every position of a 10-byte run
    for (int k = 0; k < 10; k++) begin
      lat = 1 + k % 3;
      run_op("R5 R6 match", 64'h2040, 10, fbyte(64'h2040 + 64'(k)), 6, 0, 1, 1'b0, 1'b0);
    end

    // R4: protected registers
    lat = 2;
    run_op("R4 base+index", 64'h300, 12, fbyte(64'h300 + 64'd12), 4, 5, 6, 1'b0, 1'b0);
    run_op("R4 base zero", 64'h380, 8, fbyte(64'h380 + 64'd8), 0, 0, 9, 1'b0, 1'b0);
    run_op("R4 index zero wrap R3", 64'h3C0, 8, fbyte(64'h3C0 + 64'd8), 31, 3, 0, 1'b0, 1'b0);
    run_op("R1 R4 match in guarded", 64'h400, 8, fbyte(64'h402), 12, 0, 12, 1'b0, 1'b0);

    // R7: address wrap modes
    lat = 1;
    run_op("R7 wrap32", 64'hFFFF_FFFD, 6, fbyte(64'h0000_0003), 20, 0, 2, 1'b1, 1'b0);
    run_op("R7 carry64", 64'hFFFF_FFFD, 6, fbyte(64'h1_0000_0003), 20, 0, 2, 1'b0, 1'b0);

    // R9: start during a run is ignored
    lat = 3;
    run_op("R9 start ignored", 64'h500, 8, fbyte(64'h508), 2, 0, 20, 1'b0, 1'b1);

    // R11: bench memory saw no request while one was pending
    tests++;
    if (overlap_err) begin
      fails++;
      $display("FAIL R11 overlap act=1 exp=0");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule